// File: doc/BRIEF.md
# Host-Card Control and Doorbell Register

This block is the single control and status register shared between a host bus and an embedded card processor. The host writes it to run or halt the card processor and to open the shared-memory address decode. The same register reports a latched watchdog-timeout flag. It also carries two doorbell channels in each direction: host-bound bells are raised by the card and acknowledged by the host, and card-bound bells are raised by the host and acknowledged by the card.

Halting the processor is also its reset. Once the run bit is cleared, the halt output stays asserted for at least `HOLD_CYCLES` clocks, even if software sets the run bit again at once. Clearing the run bit is the only way to clear the watchdog flag. The interrupt-enable bit gates only the host interrupt line. Pending doorbells keep setting and reading back while it is off.

Every output is registered and follows the register state that was in place during the previous clock, so it lags by one cycle. The read port shows the register state without delay.

Top module: `hcc_regs`

## Requirements
- R1: While the run bit (bit 0) is 0, `cpu_halt` and `led_red` are 1 one cycle later.
- R2: When the run bit is 1, the watchdog flag is 0 and the hold window has expired, `cpu_halt` and `led_red` are 0 one cycle later.
- R3: A `wdog_expired` pulse while the run bit is 1 sets the watchdog flag (read bit 3), which then forces `cpu_halt` and `led_red` to 1.
- R4: After the run bit goes to 0, `cpu_halt` stays 1 for at least `HOLD_CYCLES` consecutive cycles, even when the run bit is written back to 1 on the next write.
- R5: The watchdog flag is cleared only while the run bit is 0. Host writes to bit 3 have no effect on it.
- R6: `mem_dec_en` follows the memory-enable bit (bit 1) with one cycle of latency.
- R7: `host_irq` is 1 only when interrupt enable (bit 2) was 1 and at least one host-bound bell was pending. Bells set and read back regardless of bit 2.
- R8: A host-bound bell (bits 4+ch) is set by a `card_ring[ch]` pulse. A host write of 1 to its bit clears it, and a write of 0 leaves it unchanged.
- R9: A card-bound bell (bits 6+ch) is set by a host write of 1 and cleared by `card_ack[ch]`. A write of 0 leaves it unchanged, and `card_irq[ch]` follows it one cycle later.
- R10: When a set and a clear of the same bell occur in the same cycle, the bell ends up set.
- R11: After reset all register bits read 0, `cpu_halt` and `led_red` are 1, and the other outputs are 0.
- R12: A `wdog_expired` pulse while the run bit is 0 does not set the watchdog flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register readback |
| card_ring | input | 2 | Card raises host-bound bell per channel |
| card_ack | input | 2 | Card acknowledges card-bound bell per channel |
| wdog_expired | input | 1 | Watchdog timeout indication |
| cpu_halt | output | 1 | Card processor halt/reset |
| led_red | output | 1 | Forces the SYS LED red |
| mem_dec_en | output | 1 | Shared-memory decode enable |
| host_irq | output | 1 | Interrupt request to the host |
| card_irq | output | 2 | Interrupt request to the card per channel |

## Verification
The assertions assume that the strobes are only sampled on clock edges and that reset is held for at least one edge. They do not assume any exclusivity between a card ring and a host clear of the same bell, because that overlap is covered by R10. The stimulus drives each input between edges. It deliberately overlaps set and clear events, watchdog pulses with run off, and fast run toggles within the hold window. The reference model treats every such overlap as legal input.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  localparam int BIT_RUN   = 0;
  localparam int BIT_MEM   = 1;
  localparam int BIT_IE    = 2;
  localparam int BIT_WDT   = 3;
  localparam int BIT_HDB0  = 4;
  localparam int NUM_BELLS = 2;
  localparam int BIT_CDB0  = BIT_HDB0 + NUM_BELLS;
  localparam int REG_W     = BIT_CDB0 + NUM_BELLS;
endpackage

// File: rtl/hcc_hold_timer.sv
module hcc_hold_timer #(
  parameter int HOLD_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic busy
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= RELOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    !run |=> busy);
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (run && busy && $past(run)) |=> (cnt_q < $past(cnt_q)) || !run);
endmodule

// File: rtl/hcc_doorbell.sv
module hcc_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set | (flag & ~clr);
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!set && !clr) |=> flag == $past(flag));
endmodule

// File: rtl/hcc_regs.sv
module hcc_regs
  import hcc_pkg::*;
#(
  parameter int HOLD_CYCLES = 2500
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_wr,
  input  logic [REG_W-1:0]     host_wdata,
  output logic [REG_W-1:0]     host_rdata,
  input  logic [NUM_BELLS-1:0] card_ring,
  input  logic [NUM_BELLS-1:0] card_ack,
  input  logic                 wdog_expired,
  output logic                 cpu_halt,
  output logic                 led_red,
  output logic                 mem_dec_en,
  output logic                 host_irq,
  output logic [NUM_BELLS-1:0] card_irq
);
  logic run_q, mem_q, ie_q, wdt_q;
  logic hold_busy;
  logic [NUM_BELLS-1:0] hdb, cdb;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      mem_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (host_wr) begin
      run_q <= host_wdata[BIT_RUN];
      mem_q <= host_wdata[BIT_MEM];
      ie_q  <= host_wdata[BIT_IE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_q) wdt_q <= 1'b0;
    else if (wdog_expired) wdt_q <= 1'b1;
  end

  hcc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk (clk),
    .rst (rst),
    .run (run_q),
    .busy(hold_busy)
  );

  for (genvar ch = 0; ch < NUM_BELLS; ch++) begin : g_bell
    hcc_doorbell u_to_host (
      .clk (clk),
      .rst (rst),
      .set (card_ring[ch]),
      .clr (host_wr & host_wdata[BIT_HDB0+ch]),
      .flag(hdb[ch])
    );
    hcc_doorbell u_to_card (
      .clk (clk),
      .rst (rst),
      .set (host_wr & host_wdata[BIT_CDB0+ch]),
      .clr (card_ack[ch]),
      .flag(cdb[ch])
    );
  end

  logic stop_d;
  assign stop_d = !run_q || hold_busy || wdt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_halt   <= 1'b1;
      led_red    <= 1'b1;
      mem_dec_en <= 1'b0;
      host_irq   <= 1'b0;
      card_irq   <= '0;
    end else begin
      cpu_halt   <= stop_d;
      led_red    <= stop_d;
      mem_dec_en <= mem_q;
      host_irq   <= ie_q && (hdb != '0);
      card_irq   <= cdb;
    end
  end

  assign host_rdata = {cdb, hdb, wdt_q, ie_q, mem_q, run_q};

  p_stopped_halts_r1: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> cpu_halt && led_red);
  p_timeout_halts_r3: assert property (@(posedge clk) disable iff (rst)
    wdt_q |=> cpu_halt && led_red);
  p_wdt_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !wdt_q);
  p_wdt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (wdt_q && run_q) |=> wdt_q);
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> $past(ie_q) && ($past(hdb) != '0));
  p_wdt_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wdt_q) |=> !wdt_q);
endmodule

// File: tb/hcc_regs_bench.sv
module hcc_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [1:0] card_ring = '0, card_ack = '0, card_irq;
  logic wdog_expired = 1'b0;
  logic cpu_halt, led_red, mem_dec_en, host_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcc_regs #(.HOLD_CYCLES(HOLD)) u_hcc_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .card_ring(card_ring), .card_ack(card_ack),
    .wdog_expired(wdog_expired), .cpu_halt(cpu_halt), .led_red(led_red),
    .mem_dec_en(mem_dec_en), .host_irq(host_irq), .card_irq(card_irq)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_run, m_mem, m_ie, m_wdt, m_cnt;
  int m_hdb[2], m_cdb[2];
  int o_halt, o_mem, o_irq, o_cirq[2];

  task automatic model_reset();
    m_run = 0; m_mem = 0; m_ie = 0; m_wdt = 0; m_cnt = HOLD;
    m_hdb = '{0, 0}; m_cdb = '{0, 0};
    o_halt = 1; o_mem = 0; o_irq = 0; o_cirq = '{0, 0};
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      int n_run, n_mem, n_ie, n_wdt, n_cnt;
      int n_hdb[2], n_cdb[2];
      o_halt = (m_run == 0 || m_cnt != 0 || m_wdt == 1) ? 1 : 0;
      o_mem = m_mem;
      o_irq = (m_ie == 1 && (m_hdb[0] + m_hdb[1]) > 0) ? 1 : 0;
      o_cirq = m_cdb;
      n_run = host_wr ? int'(host_wdata[0]) : m_run;
      n_mem = host_wr ? int'(host_wdata[1]) : m_mem;
      n_ie  = host_wr ? int'(host_wdata[2]) : m_ie;
      if (m_run == 0) n_wdt = 0;
      else n_wdt = (m_wdt == 1 || wdog_expired) ? 1 : 0;
      if (m_run == 0) n_cnt = HOLD;
      else n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      for (int c = 0; c < 2; c++) begin
        if (card_ring[c]) n_hdb[c] = 1;
        else if (host_wr && host_wdata[4+c]) n_hdb[c] = 0;
        else n_hdb[c] = m_hdb[c];
        if (host_wr && host_wdata[6+c]) n_cdb[c] = 1;
        else if (card_ack[c]) n_cdb[c] = 0;
        else n_cdb[c] = m_cdb[c];
      end
      m_run = n_run; m_mem = n_mem; m_ie = n_ie; m_wdt = n_wdt; m_cnt = n_cnt;
      m_hdb = n_hdb; m_cdb = n_cdb;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int exp_rd;
      exp_rd = m_run | (m_mem << 1) | (m_ie << 2) | (m_wdt << 3) |
               (m_hdb[0] << 4) | (m_hdb[1] << 5) | (m_cdb[0] << 6) | (m_cdb[1] << 7);
      check("R1/R2 cpu_halt", int'(cpu_halt), o_halt);
      check("R1/R2 led_red", int'(led_red), o_halt);
      check("R6 mem_dec_en", int'(mem_dec_en), o_mem);
      check("R7 host_irq", int'(host_irq), o_irq);
      check("R9 card_irq0", int'(card_irq[0]), o_cirq[0]);
      check("R9 card_irq1", int'(card_irq[1]), o_cirq[1]);
      check("R5/R8 host_rdata", int'(host_rdata), exp_rd);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    host_wr = 1'b1; host_wdata = d;
    step();
    host_wr = 1'b0; host_wdata = '0;
  endtask

  initial begin
    int hold_len;
    step(2);
    rst = 1'b0;
    check("R11 reset rdata", int'(host_rdata), 0);
    check("R11 reset halt", int'(cpu_halt), 1);
    check("R11 reset led", int'(led_red), 1);
    check("R11 reset irq", int'(host_irq), 0);

    // R12: watchdog ignored while stopped
    wdog_expired = 1'b1; step(); wdog_expired = 1'b0; step();
    check("R12 wdt ignored", int'(host_rdata[3]), 0);

    // R2, R6: run with memory enable
    wr(8'h03);
    step(HOLD + 2);
    check("R2 running", int'(cpu_halt), 0);
    check("R6 mem on", int'(mem_dec_en), 1);

    // R7: doorbells pend with irq disabled
    card_ring = 2'b01; step(); card_ring = 2'b00; step();
    check("R7 pending no irq", int'(host_irq), 0);
    check("R7 pending bit", int'(host_rdata[4]), 1);
    wr(8'h07); step();
    check("R7 irq on", int'(host_irq), 1);

    // R8: write 0 no effect, write 1 clears
    wr(8'h07); step();
    check("R8 write0 keeps", int'(host_rdata[4]), 1);
    wr(8'h17); step();
    check("R8 write1 clears", int'(host_rdata[4]), 0);
    check("R7 irq off", int'(host_irq), 0);

    // R10: set and clear same cycle
    card_ring = 2'b10; host_wr = 1'b1; host_wdata = 8'h27;
    step(); card_ring = 2'b00; host_wr = 1'b0; host_wdata = '0;
    check("R10 host bell set wins", int'(host_rdata[5]), 1);

    // R9: card bells
    wr(8'hC7); step();
    check("R9 card irq", int'(card_irq), 3);
    card_ack = 2'b01; step(); card_ack = 2'b00; step();
    check("R9 ack clears", int'(host_rdata[7:6]), 2);
    card_ack = 2'b10; host_wr = 1'b1; host_wdata = 8'h87;
    step(); card_ack = 2'b00; host_wr = 1'b0; host_wdata = '0;
    check("R10 card bell set wins", int'(host_rdata[7]), 1);

    // R3, R5: watchdog timeout
    wdog_expired = 1'b1; step(); wdog_expired = 1'b0; step();
    check("R3 flag", int'(host_rdata[3]), 1);
    check("R3 halted", int'(cpu_halt), 1);
    wr(8'h07); step(3);
    check("R5 flag sticky", int'(host_rdata[3]), 1);
    wr(8'h0E); step();
    check("R5 flag cleared", int'(host_rdata[3]), 0);

    // R4: fast re-run keeps hold window
    wr(8'h01);
    hold_len = 0;
    for (int i = 0; i < 4 * HOLD; i++) begin
      if (cpu_halt) hold_len++;
      step();
    end
    check("R4 hold length", int'(hold_len >= HOLD), 1);
    check("R4 released", int'(cpu_halt), 0);

    // Random traffic against model
    for (int i = 0; i < 3000; i++) begin
      host_wr = ($urandom_range(0, 3) == 0);
      host_wdata = 8'($urandom);
      if (($urandom_range(0, 3)) != 0) host_wdata[0] = 1'b1;
      card_ring = 2'($urandom);
      card_ack = 2'($urandom);
      wdog_expired = ($urandom_range(0, 40) == 0);
      step();
    end
    host_wr = 1'b0; card_ring = '0; card_ack = '0; wdog_expired = 1'b0;
    step(2);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule